// File: doc/BRIEF.md
# SMBus Receive FIFO Threshold Engine

This block is the receive side of an SMBus controller running in buffered mode. It keeps a 16-entry circular byte store with a read pointer and a byte count. It fetches bytes from a serial byte receiver in bursts, and each burst ends at a programmed threshold. When the threshold is reached it raises a threshold flag, and it can ask the bus to NACK the final byte. Software reads of the data register pop bytes from the store. The block also drives the data-ready status bit, which depends on how full the store is and on whether the threshold interrupt is enabled.

Several parts of the controller sit around this block and talk to it through ports:

- The bit-level receiver delivers bytes over a request/valid handshake.
- The controller's state machine reports whether a receive is in progress or whether the final receive is being closed out with a stop.
- The register decode turns software accesses into single-cycle strobes.

The block never reorders bytes. Data leaves in the order it arrived, across any number of pointer wrap-arounds.

Top module: `rxf_engine`

## Requirements
- R1: Reset and the buffer-clear strobe both do the following: set the read pointer and count to 0, clear the threshold flag and the full flag, and abort any fill in progress. Reset also clears the LAST flag, data-ready and the data register (all read 0).
- R2: Each byte taken in a fill is stored at position (read pointer + count) mod 16. Pops therefore return bytes in arrival order, including across the wrap-around.
- R3: A fill takes one byte per handshake. It stops when the count equals the threshold. If a fill is asked for while the count already equals the threshold, no byte is requested and the count does not change.
- R4: When a fill reaches its threshold, the threshold flag goes to 1. If LAST is set at that point, `nack_o` pulses for one cycle in the cycle after the final byte is accepted, and LAST returns to 0. If LAST is clear, there is no pulse.
- R5: When a fill reaches its threshold, data-ready and the full flag are set as follows:
  - If 16 bytes are held, data-ready and the full flag both go to 1.
  - Otherwise, if the threshold interrupt enable is 0, data-ready goes to 1.
  - Otherwise, data-ready goes to 0.
- R6: If the threshold is above 16, a fill stops at 16 bytes. The count reads 16, the threshold flag reads 0, there is no NACK pulse, LAST is kept, and data-ready and the full flag are unchanged.
- R7: This requirement covers data-register reads while a receive is active and the stop-closing state is not. With a count of 0, a read starts a fill and does not pop. With a nonzero count, a read returns the byte at the read pointer, advances the pointer mod 16 and lowers the count by one.
- R8: The threshold-acknowledge strobe clears the threshold flag. It starts a fill only while a receive is active.
- R9: In the stop-closing state, a read pulses `stop_o` for one cycle if the count is 0 or 1. It pops only if the count is nonzero. A read with an empty store leaves the count at 0 and leaves the data register unchanged.
- R10: The fill-start strobe starts a fill. It stands for an accepted read-direction address, or for the start strobe written while receiving.
- R11: The LAST-set strobe makes `last_o` read 1 from the next cycle until a successful fill consumes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_clr_i | input | 1 | Buffer-clear strobe |
| thr_lvl_i | input | 5 | Receive threshold (byte count) |
| thr_ie_i | input | 1 | Threshold interrupt enable |
| last_set_i | input | 1 | Strobe that sets the one-shot LAST flag |
| rx_active_i | input | 1 | Controller is in the receiving state |
| rx_last_stop_i | input | 1 | Controller is closing the final receive with a stop |
| fill_go_i | input | 1 | Fill-start strobe |
| thr_ack_i | input | 1 | Write-one-to-clear strobe for the threshold flag |
| data_rd_i | input | 1 | Software read of the data register |
| byte_req_o | output | 1 | Byte request to the receiver |
| byte_vld_i | input | 1 | Receiver delivers a byte |
| byte_dat_i | input | 8 | Delivered byte |
| nack_o | output | 1 | One-cycle request to NACK the final byte |
| stop_o | output | 1 | One-cycle request to issue a stop |
| data_o | output | 8 | Data register |
| count_o | output | 5 | Bytes held |
| thr_flag_o | output | 1 | Threshold reached flag |
| full_o | output | 1 | Store-full flag |
| data_rdy_o | output | 1 | Data-ready status bit |
| last_o | output | 1 | LAST flag |

## Verification
The assertions take four things for granted about the inputs:
- The receiver raises `byte_vld_i` only while `byte_req_o` is high.
- The threshold input stays still while a fill is running.
- Software issues no read, acknowledge or fill-start strobe during a fill.
- Reset holds every strobe low.

The bench meets these conditions with a receiver model that offers a byte only at a falling edge where a request is showing. It also waits for the request to drop before it issues any further strobe, and it changes the threshold only between bursts.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int RXF_DEPTH_DEF = 16;
    localparam int RXF_DW_DEF    = 8;
    localparam int RXF_TW_DEF    = 5;

    // what a software read of the data register turns into
    typedef enum logic [1:0] {
        RD_IDLE,
        RD_POP,
        RD_FILL
    } rd_act_e;

    // data-ready outcome of a fill that reached its threshold
    function automatic logic rdy_pick(input logic now_full, input logic irq_en);
        return now_full || !irq_en;
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [PW-1:0] wr_idx_i,
    input  logic [DW-1:0] wr_dat_i,
    input  logic          pop_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_dat_o
);

    logic [DW-1:0] slot_q [DEPTH];
    logic [DW-1:0] dat_d, dat_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_idx_i == PW'(g))) begin
                slot_q[g] <= wr_dat_i;
            end
        end
    end

    always_comb begin
        dat_d = dat_q;
        if (pop_i) begin
            dat_d = slot_q[rd_idx_i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q <= '0;
        end else begin
            dat_q <= dat_d;
        end
    end

    assign rd_dat_o = dat_q;

endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TW    = 5,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH) + 1,
    localparam int CMPW = (CW > TW) ? CW : TW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [TW-1:0] thr_i,
    input  logic          thr_ie_i,
    input  logic          last_set_i,
    input  logic          rx_active_i,
    input  logic          rx_last_stop_i,
    input  logic          fill_go_i,
    input  logic          thr_ack_i,
    input  logic          rd_i,
    input  logic          byte_vld_i,
    output logic          wr_en_o,
    output logic [PW-1:0] wr_idx_o,
    output logic          pop_o,
    output logic [PW-1:0] rd_idx_o,
    output logic          req_o,
    output logic          nack_o,
    output logic          stop_o,
    output logic [CW-1:0] count_o,
    output logic          thr_flag_o,
    output logic          full_o,
    output logic          rdy_o,
    output logic          last_o
);

    typedef struct packed {
        logic          filling;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          thr_flag;
        logic          full;
        logic          rdy;
        logic          last;
        logic          nack;
        logic          stop;
    } ctl_t;

    ctl_t q, d;

    logic [CMPW-1:0] thr_x, cnt_x, cntn_x;
    logic [CW-1:0]   cnt_n;
    logic            start;
    rd_act_e         rd_act;

    assign thr_x  = CMPW'(thr_i);
    assign cnt_x  = CMPW'(q.cnt);
    assign cnt_n  = q.cnt + CW'(1);
    assign cntn_x = CMPW'(cnt_n);

    // decode of a data-register read outside a fill
    always_comb begin
        rd_act = RD_IDLE;
        if (rd_i && !q.filling) begin
            if (rx_last_stop_i) begin
                rd_act = (q.cnt != '0) ? RD_POP : RD_IDLE;
            end else if (rx_active_i) begin
                rd_act = (q.cnt == '0) ? RD_FILL : RD_POP;
            end
        end
    end

    always_comb begin
        d        = q;
        d.nack   = 1'b0;
        d.stop   = 1'b0;
        start    = 1'b0;
        wr_en_o  = 1'b0;
        pop_o    = 1'b0;
        wr_idx_o = q.rp + q.cnt[PW-1:0];

        if (clr_i) begin
            d.filling  = 1'b0;
            d.rp       = '0;
            d.cnt      = '0;
            d.thr_flag = 1'b0;
            d.full     = 1'b0;
        end else if (q.filling) begin
            if (byte_vld_i) begin
                wr_en_o = 1'b1;
                d.cnt   = cnt_n;
                if (cntn_x == thr_x) begin
                    d.filling  = 1'b0;
                    d.thr_flag = 1'b1;
                    if (q.last) begin
                        d.nack = 1'b1;
                        d.last = 1'b0;
                    end
                    d.rdy = rdy_pick(cnt_n == CW'(DEPTH), thr_ie_i);
                    if (cnt_n == CW'(DEPTH)) begin
                        d.full = 1'b1;
                    end
                end else if (cnt_n == CW'(DEPTH)) begin
                    // threshold beyond capacity: keep the bytes, report nothing
                    d.filling  = 1'b0;
                    d.thr_flag = 1'b0;
                end
            end
        end else begin
            if (rd_i && rx_last_stop_i && (q.cnt <= CW'(1))) begin
                d.stop = 1'b1;
            end
            if (rd_act == RD_POP) begin
                pop_o = 1'b1;
                d.rp  = q.rp + PW'(1);
                d.cnt = q.cnt - CW'(1);
            end
            if (rd_act == RD_FILL) begin
                start = 1'b1;
            end
            if (thr_ack_i) begin
                d.thr_flag = 1'b0;
                if (rx_active_i) begin
                    start = 1'b1;
                end
            end
            if (fill_go_i) begin
                start = 1'b1;
            end
            if (start && (cnt_x != thr_x)) begin
                d.thr_flag = 1'b0;
                if ((cnt_x < thr_x) && (q.cnt != CW'(DEPTH))) begin
                    d.filling = 1'b1;
                end
            end
        end

        if (last_set_i) begin
            d.last = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_idx_o   = q.rp;
    assign req_o      = q.filling;
    assign nack_o     = q.nack;
    assign stop_o     = q.stop;
    assign count_o    = q.cnt;
    assign thr_flag_o = q.thr_flag;
    assign full_o     = q.full;
    assign rdy_o      = q.rdy;
    assign last_o     = q.last;

endmodule

// File: rtl/rxf_engine.sv
module rxf_engine
    import rxf_pkg::*;
#(
    parameter int DEPTH = RXF_DEPTH_DEF,
    parameter int DW    = RXF_DW_DEF,
    parameter int TW    = RXF_TW_DEF,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_clr_i,
    input  logic [TW-1:0] thr_lvl_i,
    input  logic          thr_ie_i,
    input  logic          last_set_i,
    input  logic          rx_active_i,
    input  logic          rx_last_stop_i,
    input  logic          fill_go_i,
    input  logic          thr_ack_i,
    input  logic          data_rd_i,
    output logic          byte_req_o,
    input  logic          byte_vld_i,
    input  logic [DW-1:0] byte_dat_i,
    output logic          nack_o,
    output logic          stop_o,
    output logic [DW-1:0] data_o,
    output logic [CW-1:0] count_o,
    output logic          thr_flag_o,
    output logic          full_o,
    output logic          data_rdy_o,
    output logic          last_o
);

    logic          wr_en;
    logic [PW-1:0] wr_idx;
    logic          pop;
    logic [PW-1:0] rd_idx;

    rxf_ctrl #(
        .DEPTH (DEPTH),
        .TW    (TW)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr_i          (buf_clr_i),
        .thr_i          (thr_lvl_i),
        .thr_ie_i       (thr_ie_i),
        .last_set_i     (last_set_i),
        .rx_active_i    (rx_active_i),
        .rx_last_stop_i (rx_last_stop_i),
        .fill_go_i      (fill_go_i),
        .thr_ack_i      (thr_ack_i),
        .rd_i           (data_rd_i),
        .byte_vld_i     (byte_vld_i),
        .wr_en_o        (wr_en),
        .wr_idx_o       (wr_idx),
        .pop_o          (pop),
        .rd_idx_o       (rd_idx),
        .req_o          (byte_req_o),
        .nack_o         (nack_o),
        .stop_o         (stop_o),
        .count_o        (count_o),
        .thr_flag_o     (thr_flag_o),
        .full_o         (full_o),
        .rdy_o          (data_rdy_o),
        .last_o         (last_o)
    );

    rxf_store #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .wr_dat_i (byte_dat_i),
        .pop_i    (pop),
        .rd_idx_i (rd_idx),
        .rd_dat_o (data_o)
    );

endmodule

// File: rtl/rxf_engine_chk.sv
module rxf_engine_chk #(
    parameter int DEPTH = 16,
    parameter int TW    = 5,
    localparam int CW   = $clog2(DEPTH) + 1,
    localparam int CMPW = (CW > TW) ? CW : TW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          buf_clr_i,
    input logic [TW-1:0] thr_lvl_i,
    input logic          rx_last_stop_i,
    input logic          data_rd_i,
    input logic          byte_req_o,
    input logic          byte_vld_i,
    input logic          nack_o,
    input logic          stop_o,
    input logic [CW-1:0] count_o,
    input logic          thr_flag_o,
    input logic          full_o
);

    // R2: the receiver offers a byte only against a request
    p_vld_in_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_i |-> byte_req_o);

    // R3: a request is never outstanding once the threshold count is held
    p_req_below_thr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req_o |-> (CMPW'(count_o) != CMPW'(thr_lvl_i)));

    // R6: the count never passes the store depth
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));

    // R4: a NACK request only comes with a reached threshold
    p_nack_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nack_o |-> thr_flag_o);

    // R5: the full flag rises only with a full store
    p_full_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> (count_o == CW'(DEPTH)));

    // R9: a stop request follows a read in the stop-closing state
    p_stop_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> $past(data_rd_i && rx_last_stop_i));

    // R1: a clear empties the store and drops both flags
    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        buf_clr_i |=> (count_o == '0) && !thr_flag_o && !full_o && !byte_req_o);

endmodule

bind rxf_engine rxf_engine_chk #(
    .DEPTH (DEPTH),
    .TW    (TW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .buf_clr_i      (buf_clr_i),
    .thr_lvl_i      (thr_lvl_i),
    .rx_last_stop_i (rx_last_stop_i),
    .data_rd_i      (data_rd_i),
    .byte_req_o     (byte_req_o),
    .byte_vld_i     (byte_vld_i),
    .nack_o         (nack_o),
    .stop_o         (stop_o),
    .count_o        (count_o),
    .thr_flag_o     (thr_flag_o),
    .full_o         (full_o)
);

// File: tb/sim_rxf_engine.sv
module sim_rxf_engine;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 60000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       buf_clr = 1'b0;
    logic [4:0] thr_lvl = '0;
    logic       thr_ie = 1'b0;
    logic       last_set = 1'b0;
    logic       rx_active = 1'b0;
    logic       rx_last_stop = 1'b0;
    logic       fill_go = 1'b0;
    logic       thr_ack = 1'b0;
    logic       data_rd = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_dat = '0;
    logic       byte_req, nack, stop, thr_flag, full, data_rdy, last;
    logic [7:0] data;
    logic [4:0] count;

    int n_chk = 0;
    int n_fail = 0;
    int nack_cnt = 0;
    int stop_cnt = 0;
    logic [7:0] src_seq = 8'h30;
    logic [7:0] pop_seq = 8'h30;
    bit   rdy_exp = 1'b0;
    bit   full_exp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxf_engine u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .buf_clr_i      (buf_clr),
        .thr_lvl_i      (thr_lvl),
        .thr_ie_i       (thr_ie),
        .last_set_i     (last_set),
        .rx_active_i    (rx_active),
        .rx_last_stop_i (rx_last_stop),
        .fill_go_i      (fill_go),
        .thr_ack_i      (thr_ack),
        .data_rd_i      (data_rd),
        .byte_req_o     (byte_req),
        .byte_vld_i     (byte_vld),
        .byte_dat_i     (byte_dat),
        .nack_o         (nack),
        .stop_o         (stop),
        .data_o         (data),
        .count_o        (count),
        .thr_flag_o     (thr_flag),
        .full_o         (full),
        .data_rdy_o     (data_rdy),
        .last_o         (last)
    );

    // byte receiver model: offers the next byte whenever a request shows
    initial begin
        forever begin
            @(negedge clk);
            if (byte_vld) src_seq = src_seq + 8'd1;
            byte_vld = byte_req;
            byte_dat = src_seq;
        end
    end

    // pulse monitor
    initial begin
        forever begin
            @(negedge clk);
            if (nack) nack_cnt++;
            if (stop) stop_cnt++;
        end
    end

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 100; i++) begin
            if (!byte_req) break;
            tick();
        end
        chk(!byte_req, "R3 fill ends", int'(byte_req), 0);
        tick();
    endtask

    task automatic do_clr;
        buf_clr = 1'b1;
        tick();
        buf_clr = 1'b0;
        pop_seq = src_seq;
        full_exp = 1'b0;
    endtask

    task automatic pop_one(input string rq);
        data_rd = 1'b1;
        tick();
        data_rd = 1'b0;
        chk(data == pop_seq, rq, int'(data), int'(pop_seq));
        pop_seq = pop_seq + 8'd1;
    endtask

    task automatic batch(input int thr, input bit ie, input bit lst);
        int n0;
        thr_lvl = 5'(thr);
        thr_ie  = ie;
        if (lst) begin
            last_set = 1'b1;
            tick();
            last_set = 1'b0;
            chk(last == 1'b1, "R11 last set", int'(last), 1);
        end
        n0 = nack_cnt;
        fill_go = 1'b1;
        tick();
        fill_go = 1'b0;
        chk(byte_req == 1'b1, "R10 fill started", int'(byte_req), 1);
        wait_idle();
        chk(int'(count) == thr, "R3 count at threshold", int'(count), thr);
        chk(thr_flag == 1'b1, "R4 threshold flag", int'(thr_flag), 1);
        chk(nack_cnt - n0 == int'(lst), "R4 nack pulses", nack_cnt - n0, int'(lst));
        chk(last == 1'b0, "R4 last consumed", int'(last), 0);
        rdy_exp = (thr == 16) || !ie;
        if (thr == 16) full_exp = 1'b1;
        chk(data_rdy == rdy_exp, "R5 data ready", int'(data_rdy), int'(rdy_exp));
        chk(full == full_exp, "R5 full flag", int'(full), int'(full_exp));
        rx_active = 1'b1;
        for (int i = 0; i < thr; i++) pop_one("R2 pop order");
        chk(count == 5'd0, "R7 drained", int'(count), 0);
        rx_active = 1'b0;
    endtask

    initial begin
        int prev_rdy;
        logic [7:0] prev_dat;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(count == 0 && !thr_flag && !full && !byte_req, "R1 reset flags", int'(count), 0);
        chk(!last && !data_rdy && data == 8'd0, "R1 reset last/rdy/data", int'(data), 0);

        // sweep of threshold, enable and LAST without clearing: wraps pointer
        for (int t = 1; t <= 16; t++)
            for (int m = 0; m < 4; m++)
                batch(t, m[0], m[1]);

        // R3: fill requested at threshold does nothing
        do_clr();
        thr_lvl = 5'd3;
        fill_go = 1'b1; tick(); fill_go = 1'b0;
        wait_idle();
        chk(count == 5'd3, "R3 first fill", int'(count), 3);
        fill_go = 1'b1; tick(); fill_go = 1'b0;
        chk(byte_req == 1'b0, "R3 no request at threshold", int'(byte_req), 0);
        tick();
        chk(count == 5'd3, "R3 count kept", int'(count), 3);

        // R8: acknowledge without receiving only clears the flag
        thr_ack = 1'b1; tick(); thr_ack = 1'b0;
        chk(thr_flag == 1'b0, "R8 flag cleared", int'(thr_flag), 0);
        tick();
        chk(byte_req == 1'b0 && count == 5'd3, "R8 no fill when idle", int'(count), 3);
        rx_active = 1'b1;
        pop_one("R7 pop");
        thr_ack = 1'b1; tick(); thr_ack = 1'b0;
        wait_idle();
        chk(count == 5'd3, "R8 refill count", int'(count), 3);
        chk(thr_flag == 1'b1, "R8 refill flag", int'(thr_flag), 1);
        for (int i = 0; i < 3; i++) pop_one("R2 pop after refill");

        // R7: read at empty while receiving starts a fill, no pop
        prev_dat = data;
        data_rd = 1'b1; tick(); data_rd = 1'b0;
        chk(byte_req == 1'b1, "R7 read starts fill", int'(byte_req), 1);
        wait_idle();
        chk(count == 5'd3, "R7 fill count", int'(count), 3);
        chk(data == prev_dat, "R7 no pop on empty", int'(data), int'(prev_dat));
        for (int i = 0; i < 3; i++) pop_one("R7 pop");
        rx_active = 1'b0;

        // R9: stop-closing reads
        thr_lvl = 5'd2;
        fill_go = 1'b1; tick(); fill_go = 1'b0;
        wait_idle();
        rx_last_stop = 1'b1;
        begin
            int s0;
            s0 = stop_cnt;
            pop_one("R9 pop at two");
            tick();
            chk(stop_cnt == s0, "R9 no stop at two", stop_cnt - s0, 0);
            pop_one("R9 pop at one");
            tick();
            chk(stop_cnt == s0 + 1, "R9 stop at one", stop_cnt - s0, 1);
            prev_dat = data;
            data_rd = 1'b1; tick(); data_rd = 1'b0;
            tick();
            chk(stop_cnt == s0 + 2, "R9 stop at empty", stop_cnt - s0, 2);
            chk(count == 5'd0, "R9 count stays empty", int'(count), 0);
            chk(data == prev_dat, "R9 data unchanged", int'(data), int'(prev_dat));
        end
        rx_last_stop = 1'b0;

        // R6: threshold above capacity
        do_clr();
        thr_lvl = 5'd20;
        thr_ie = 1'b0;
        last_set = 1'b1; tick(); last_set = 1'b0;
        prev_rdy = int'(data_rdy);
        begin
            int n0;
            n0 = nack_cnt;
            fill_go = 1'b1; tick(); fill_go = 1'b0;
            wait_idle();
            tick();
            chk(count == 5'd16, "R6 count stops at 16", int'(count), 16);
            chk(thr_flag == 1'b0, "R6 no flag", int'(thr_flag), 0);
            chk(nack_cnt == n0, "R6 no nack", nack_cnt - n0, 0);
            chk(last == 1'b1, "R6 last kept", int'(last), 1);
            chk(int'(data_rdy) == prev_rdy, "R6 ready unchanged", int'(data_rdy), prev_rdy);
            chk(full == 1'b0, "R6 full unchanged", int'(full), 0);
        end
        rx_active = 1'b1;
        for (int i = 0; i < 16; i++) pop_one("R6 held bytes in order");
        rx_active = 1'b0;

        // R1: clear mid-content
        thr_lvl = 5'd5;
        fill_go = 1'b1; tick(); fill_go = 1'b0;
        wait_idle();
        do_clr();
        chk(count == 0 && !thr_flag && !full, "R1 clear", int'(count), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule